// File: doc/BRIEF.md
# Sticky Interrupt Status Field

This block is a single interrupt status field of parameterised width. It watches a vector of hardware event lines and holds what it sees until software clears it. Each instance is built for one capture style: the level of the lines, their rising edges, their falling edges, or any change. The three edge styles compare each line with a registered copy of its value from the previous clock.

An instance can be built in either of two hold styles. In per-bit hold, every bit latches on its own and bits accumulate. In whole-word hold, the first non-zero event vector is stored as a whole and then frozen until software brings the field back to zero. Capture can be gated by an enable input that is active high or active low, or the enable can be left unused.

Software clears bits with a write-one-to-clear strobe. A build-time switch decides whether the hardware capture or the software clear wins when both want to update the field in the same cycle. The field raises an interrupt request whenever any stored bit is set.

Top module: `sticky_irq_field`

## Requirements
- R1: After reset, status_o and irq_o are zero and the registered copy of sig_i is zero. In rising, falling and any-change modes, the first post-reset sample of sig_i is compared against all zeros.
- R2: In level mode (CAPTURE=CAP_LEVEL, encoding 0), every bit of sig_i that is high when sampled counts as an event. No status bit can become set in a cycle without a gated event on it.
- R3: In rising mode (CAP_RISE, encoding 1), bit i has an event when it was 0 at the previous clock edge and is 1 at the current edge.
- R4: In falling mode (CAP_FALL, encoding 2), bit i has an event when it was 1 at the previous clock edge and is 0 at the current edge.
- R5: In any-change mode (CAP_BOTH, encoding 3), bit i has an event whenever its value differs from the previous clock edge.
- R6: In per-bit hold (HOLD=HOLD_BITS, encoding 0), an update by hardware ORs the gated events into status. Set bits stay set until cleared.
- R7: In whole-word hold (HOLD=HOLD_WORD, encoding 1), a capture happens only when the stored value is zero and the gated event vector is non-zero; the event vector is then stored as a whole. A non-zero stored value is frozen except by a software clear.
- R8: Enable gating works as follows. With GATE_HIGH (encoding 1), events count only when en_i=1. With GATE_LOW (encoding 2), events count only when en_i=0. With GATE_NONE (encoding 0), en_i has no effect.
- R9: When clr_we_i=1 and the clear is applied, each status bit whose clr_mask_i bit is 1 is cleared, and the other bits are kept. When clr_we_i=0, clr_mask_i has no effect.
- R10: With HW_WINS=0, a cycle with clr_we_i=1 applies only the clear, and the hardware events of that cycle are dropped.
- R11: With HW_WINS=1, a cycle in which hardware captures applies only the capture, and a clear in that cycle is dropped. A hardware capture means any gated event in per-bit hold, or a zero stored value with a non-zero event vector in whole-word hold.
- R12: irq_o is 1 exactly when status_o is non-zero, in the same cycle.
- R13: An input sampled at clock edge k, whether event or clear, is visible on status_o and irq_o right after edge k. There is one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | WIDTH | Hardware event lines |
| en_i | input | 1 | Capture enable, polarity set by GATE |
| clr_we_i | input | 1 | Software clear write strobe |
| clr_mask_i | input | WIDTH | Write-one-to-clear data |
| status_o | output | WIDTH | Stored status bits |
| irq_o | output | 1 | Interrupt request, OR of status bits |

## Verification
Every result of this block is due one clock after the edge that samples its cause. This holds for edge detection too, because the registered copy and the status register update on the same edge. Inputs are driven on the falling edge and held across the next rising edge. The behavioural model advances on that rising edge from the same inputs, and the comparison runs 2 ns after the edge, once the design outputs have settled. Directed checks are placed on the falling edge after the stimulus cycle, and their expected values are worked out from the mode rules.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    CAP_LEVEL = 2'd0,
    CAP_RISE  = 2'd1,
    CAP_FALL  = 2'd2,
    CAP_BOTH  = 2'd3
  } capture_e;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_HIGH = 2'd1,
    GATE_LOW  = 2'd2
  } gate_e;

  typedef enum logic {
    HOLD_BITS = 1'b0,
    HOLD_WORD = 1'b1
  } hold_e;
endpackage

// File: rtl/sirq_event_detect.sv
module sirq_event_detect
  import sirq_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter capture_e    CAPTURE = CAP_RISE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] evt_o
);

  if (CAPTURE == CAP_LEVEL) begin : g_level
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign evt_o = sig_i;
  end else begin : g_edge
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] fall;

    // cleared at reset so the first sample is compared against zero
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= sig_i;
    end

    assign rise = sig_i & ~prev_q;
    assign fall = prev_q & ~sig_i;

    if (CAPTURE == CAP_RISE) begin : g_rise
      assign evt_o = rise;
    end else if (CAPTURE == CAP_FALL) begin : g_fall
      assign evt_o = fall;
    end else begin : g_both
      assign evt_o = rise | fall;
    end
  end

endmodule

// File: rtl/sirq_gate.sv
module sirq_gate
  import sirq_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter gate_e       GATE  = GATE_NONE
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] evt_i,
  output logic [WIDTH-1:0] hit_o
);

  if (GATE == GATE_HIGH) begin : g_high
    assign hit_o = en_i ? evt_i : '0;
  end else if (GATE == GATE_LOW) begin : g_low
    assign hit_o = en_i ? '0 : evt_i;
  end else begin : g_none
    logic unused_en;
    assign unused_en = en_i;
    assign hit_o = evt_i;
  end

endmodule

// File: rtl/sirq_store.sv
module sirq_store
  import sirq_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter hold_e       HOLD    = HOLD_BITS,
  parameter bit          HW_WINS = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] hit_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  output logic [WIDTH-1:0] status_o
);

  logic [WIDTH-1:0] stat_q;
  logic [WIDTH-1:0] stat_d;
  logic [WIDTH-1:0] hw_val;
  logic [WIDTH-1:0] sw_val;
  logic             hw_take;

  if (HOLD == HOLD_BITS) begin : g_bits
    assign hw_take = |hit_i;
    assign hw_val  = stat_q | hit_i;
  end else begin : g_word
    assign hw_take = ~|stat_q & |hit_i;
    assign hw_val  = hit_i;
  end

  assign sw_val = stat_q & ~clr_mask_i;

  if (HW_WINS) begin : g_hw_first
    always_comb begin
      if (hw_take)       stat_d = hw_val;
      else if (clr_we_i) stat_d = sw_val;
      else               stat_d = stat_q;
    end
  end else begin : g_sw_first
    always_comb begin
      if (clr_we_i)     stat_d = sw_val;
      else if (hw_take) stat_d = hw_val;
      else              stat_d = stat_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign status_o = stat_q;

  AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i == '0) |=> ((status_o & ~$past(status_o)) == '0)); // R2

  if (HOLD == HOLD_BITS) begin : g_ast_bits
    AST_BITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_we_i |=> (($past(status_o) & ~status_o) == '0)); // R6
  end else begin : g_ast_word
    AST_WORD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_o != '0) && !clr_we_i) |=> $stable(status_o)); // R7
  end

  if (!HW_WINS) begin : g_ast_sw
    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i |=> ((status_o & $past(clr_mask_i)) == '0)); // R10
  end else if (HOLD == HOLD_BITS) begin : g_ast_hw
    AST_HW_OVERRIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i != '0) |=> ((status_o & $past(hit_i | status_o)) == $past(hit_i | status_o))); // R11
  end

endmodule

// File: rtl/sticky_irq_field.sv
module sticky_irq_field
  import sirq_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter capture_e    CAPTURE = CAP_RISE,
  parameter hold_e       HOLD    = HOLD_BITS,
  parameter gate_e       GATE    = GATE_NONE,
  parameter bit          HW_WINS = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  input  logic             en_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] evt;
  logic [WIDTH-1:0] hit;

  sirq_event_detect #(
    .WIDTH  (WIDTH),
    .CAPTURE(CAPTURE)
  ) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_i),
    .evt_o (evt)
  );

  sirq_gate #(
    .WIDTH(WIDTH),
    .GATE (GATE)
  ) u_gate (
    .en_i (en_i),
    .evt_i(evt),
    .hit_o(hit)
  );

  sirq_store #(
    .WIDTH  (WIDTH),
    .HOLD   (HOLD),
    .HW_WINS(HW_WINS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .clr_we_i  (clr_we_i),
    .clr_mask_i(clr_mask_i),
    .status_o  (status_o)
  );

  assign irq_o = |status_o;

  if (GATE == GATE_HIGH) begin : g_ast_gh
    AST_GATE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> ((status_o & ~$past(status_o)) == '0)); // R8
  end else if (GATE == GATE_LOW) begin : g_ast_gl
    AST_GATE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> ((status_o & ~$past(status_o)) == '0)); // R8
  end

endmodule

// File: tb/tb_sticky_irq_field.sv
`timescale 1ns/1ps
module tb_sticky_irq_field;
  import sirq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sig = '0;
  logic       en = 1'b0;
  logic       we = 1'b0;
  logic [7:0] cm = '0;
  logic [7:0] st [4];
  logic       irq [4];

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R13";

  logic [7:0] mq [4];
  logic [7:0] mprev;

  always #4 clk = ~clk;

  // 0: rise/bits/gate-high/sw-first  1: level/word/none/hw-first
  // 2: both/bits/gate-low/hw-first   3: fall/word/none/sw-first
  sticky_irq_field #(.WIDTH(8), .CAPTURE(CAP_RISE), .HOLD(HOLD_BITS), .GATE(GATE_HIGH), .HW_WINS(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .en_i(en), .clr_we_i(we), .clr_mask_i(cm),
    .status_o(st[0]), .irq_o(irq[0]));
  sticky_irq_field #(.WIDTH(8), .CAPTURE(CAP_LEVEL), .HOLD(HOLD_WORD), .GATE(GATE_NONE), .HW_WINS(1'b1)) u_lvl (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .en_i(en), .clr_we_i(we), .clr_mask_i(cm),
    .status_o(st[1]), .irq_o(irq[1]));
  sticky_irq_field #(.WIDTH(8), .CAPTURE(CAP_BOTH), .HOLD(HOLD_BITS), .GATE(GATE_LOW), .HW_WINS(1'b1)) u_both (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .en_i(en), .clr_we_i(we), .clr_mask_i(cm),
    .status_o(st[2]), .irq_o(irq[2]));
  sticky_irq_field #(.WIDTH(8), .CAPTURE(CAP_FALL), .HOLD(HOLD_WORD), .GATE(GATE_NONE), .HW_WINS(1'b0)) u_fall (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .en_i(en), .clr_we_i(we), .clr_mask_i(cm),
    .status_o(st[3]), .irq_o(irq[3]));

  function automatic logic [7:0] ref_next(int idx, logic [7:0] q, logic [7:0] s, logic [7:0] p,
                                          logic e, logic w, logic [7:0] m);
    int  cap;
    int  gate;
    bit  word;
    bit  hwf;
    bit  pass;
    bit  take;
    logic [7:0] ev;
    logic [7:0] hv;
    case (idx)
      0:       begin cap = 1; word = 0; gate = 1; hwf = 0; end
      1:       begin cap = 0; word = 1; gate = 0; hwf = 1; end
      2:       begin cap = 3; word = 0; gate = 2; hwf = 1; end
      default: begin cap = 2; word = 1; gate = 0; hwf = 0; end
    endcase
    ev = '0;
    for (int b = 0; b < 8; b++) begin
      if (cap == 0 && s[b]) ev[b] = 1'b1;
      if (cap == 1 && s[b] && !p[b]) ev[b] = 1'b1;
      if (cap == 2 && !s[b] && p[b]) ev[b] = 1'b1;
      if (cap == 3 && s[b] != p[b]) ev[b] = 1'b1;
    end
    pass = (gate == 0) || (gate == 1 && e) || (gate == 2 && !e);
    if (!pass) ev = '0;
    if (word) begin
      take = (q == 0) && (ev != 0);
      hv = ev;
    end else begin
      take = (ev != 0);
      hv = q | ev;
    end
    if (hwf) begin
      if (take) return hv;
      if (w) return q & ~m;
      return q;
    end
    if (w) return q & ~m;
    if (take) return hv;
    return q;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mq[i] <= '0;
      mprev <= '0;
    end else begin
      for (int i = 0; i < 4; i++) mq[i] <= ref_next(i, mq[i], sig, mprev, en, we, cm);
      mprev <= sig;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int i = 0; i < 4; i++) begin
        chk(cur_req, $sformatf("model status[%0d]", i), st[i], mq[i]);
        chk("R12", $sformatf("model irq[%0d]", i), {7'd0, irq[i]}, {7'd0, (mq[i] != 0)});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R13 watchdog act=%0d exp=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(logic [7:0] s, logic e, logic w, logic [7:0] m);
    sig = s; en = e; we = w; cm = m;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin
      chk("R1", "reset status", st[i], 8'h00);
      chk("R1", "reset irq", {7'd0, irq[i]}, 8'h00);
    end

    cur_req = "R3";
    drive(8'h05, 1'b1, 1'b0, 8'h00); tick();
    chk("R3", "rise captured", st[0], 8'h05);
    chk("R2", "level captured", st[1], 8'h05);
    chk("R8", "gate low blocks en=1", st[2], 8'h00);
    chk("R4", "no fall yet", st[3], 8'h00);
    chk("R12", "irq high", {7'd0, irq[0]}, 8'h01);

    cur_req = "R4";
    drive(8'h01, 1'b0, 1'b0, 8'h00); tick();
    chk("R6", "rise holds", st[0], 8'h05);
    chk("R7", "word frozen", st[1], 8'h05);
    chk("R5", "both sees fall", st[2], 8'h04);
    chk("R4", "fall captured", st[3], 8'h04);

    cur_req = "R9";
    drive(8'h01, 1'b0, 1'b1, 8'h04); tick();
    chk("R9", "w1c partial", st[0], 8'h01);
    chk("R9", "w1c word", st[1], 8'h01);
    chk("R9", "w1c both", st[2], 8'h00);

    cur_req = "R10";
    drive(8'h03, 1'b1, 1'b1, 8'h01); tick();
    chk("R10", "clear wins, rise dropped", st[0], 8'h00);
    chk("R9", "word cleared", st[1], 8'h00);

    cur_req = "R5";
    drive(8'h02, 1'b0, 1'b0, 8'h00); tick();
    chk("R2", "level recapture", st[1], 8'h02);
    chk("R5", "both fall bit0", st[2], 8'h01);
    chk("R4", "fall bit0", st[3], 8'h01);

    cur_req = "R11";
    drive(8'h06, 1'b0, 1'b1, 8'hFF); tick();
    chk("R11", "hw wins over clear", st[2], 8'h05);
    chk("R9", "word cleared, hw-first no capture", st[1], 8'h00);
    chk("R10", "word sw-first cleared", st[3], 8'h00);

    cur_req = "R9";
    drive(8'h06, 1'b0, 1'b0, 8'hFF); tick();
    chk("R9", "mask ignored w/o strobe", st[2], 8'h05);
    chk("R7", "word recapture from zero", st[1], 8'h06);
    chk("R12", "irq low", {7'd0, irq[0]}, 8'h00);

    cur_req = "R6";
    drive(8'h16, 1'b1, 1'b0, 8'h00); tick();
    chk("R3", "rise bit4", st[0], 8'h10);
    drive(8'h36, 1'b1, 1'b0, 8'h00); tick();
    chk("R6", "bits accumulate", st[0], 8'h30);

    cur_req = "R13";
    for (int n = 0; n < 400; n++) begin
      drive(8'($urandom), 1'($urandom), ($urandom % 4) == 0, 8'($urandom));
      tick();
    end
    drive(8'h00, 1'b0, 1'b0, 8'h00);
    tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule